// File: doc/BRIEF.md
# Row-Based Lane Data Sharing Unit

This block moves 32-bit values between the lanes of a 64-lane wavefront ahead of the arithmetic stage. The lanes are grouped into four rows of sixteen. Each row holds four banks of four lanes, so the row of lane `i` is `i[5:4]` and its bank is `i[3:2]`. For every lane, a control code picks a source lane. The pick can be a permutation inside a row, a broadcast between rows, a one-lane move across the whole wavefront, or an arbitrary pick inside each group of eight lanes. The picked value is then filtered by row and bank enables, the exec mask, and the rules for invalid and inactive sources.

A lane that is not written keeps the previous destination value supplied on `old_data`. A 32-lane mode uses only rows 0 and 1. The result is registered, so it appears one cycle after `in_valid` and holds until the next accepted request.

Top module: `lane_share_unit`

## Requirements
- R1: With `op`=0 (quad permute), lane `i` reads lane `4*(i/4) + arg[2k+1:2k]`, where `k = i%4`.
- R2: With `op`=1, lane `i` reads the lane at `15-(i%16)` in its own row. With `op`=2, lane `i` reads the lane at `7-(i%8)` in its own 8-lane half-row.
- R3: With `op`=3, lane `i` reads row position `(i%16)+n`, where `n = arg[3:0]`. With `op`=4, it reads `(i%16)-n`. Either source is invalid when it falls outside 0..15. With `op`=5, it reads `((i%16)-n) mod 16`. All three stay inside the row.
- R4: With `op`=6, lane `i` reads `i+1`, and the last lane of the wave is invalid. With `op`=7, it reads `i+1` and wraps to lane 0. With `op`=8, it reads `i-1`, and lane 0 is invalid. With `op`=9, it reads `i-1` and wraps to the last lane.
- R5: With `op`=10, every lane of row r≥1 reads lane `16r-1`, and row 0 is invalid. With `op`=11, rows 2 and 3 read lane 31, and rows 0 and 1 are invalid. Any other `op` value copies the lane's own source.
- R6: Outside 8-lane mode, a lane whose row bit in `row_en` or whose bank bit in `bank_en` is 0 keeps its `old_data` value.
- R7: An invalid source gives zero when `bound_zero`=1. When `bound_zero`=0, the lane keeps its `old_data` value.
- R8: A source lane whose exec bit is 0 supplies its `src_data` value when `fetch_inact`=1. When `fetch_inact`=0, it is treated as an invalid source (R7).
- R9: With `mode8`=1, lane `i` reads `8*(i/8) + sel8[3k+2:3k]`, where `k = i%8`. In this mode `row_en` and `bank_en` are ignored. An inactive source gives zero unless `fetch_inact`=1.
- R10: A destination lane whose own exec bit is 0 keeps its `old_data` value.
- R11: With `wave32`=1, lanes 32..63 keep `old_data`, and lane 31 is the last lane for the R4 moves.
- R12: After reset, `out_valid`=0 and `result`=0. `out_valid` follows `in_valid` one cycle later. `result` changes only on the cycle after an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_data | input | 2048 | Source value of each lane, lane i at [32i+31:32i] |
| old_data | input | 2048 | Previous destination value of each lane |
| exec_mask | input | 64 | Active lanes |
| op | input | 4 | Movement pattern code |
| arg | input | 8 | Selectors or shift amount for `op` |
| sel8 | input | 24 | Eight 3-bit selectors for 8-lane mode |
| mode8 | input | 1 | Select 8-lane arbitrary mode |
| wave32 | input | 1 | 32-lane wavefront |
| row_en | input | 4 | Per-row write enable |
| bank_en | input | 4 | Per-bank write enable |
| bound_zero | input | 1 | Invalid source gives zero |
| fetch_inact | input | 1 | Read inactive source lanes anyway |
| out_valid | output | 1 | Result strobe |
| result | output | 2048 | Per-lane result |

## Verification
Every source lane carries a distinct value and every old value is distinct, so a wrong source index, a wrong keep-versus-zero choice, or a wrong lane ordering each shows up as a specific mismatched lane.

Each row-local pattern is run with amounts that both reach and do not reach a row edge, and with each `bound_zero` setting. This separates row-edge invalidity from wave-edge invalidity.

Irregular exec patterns are combined with both `fetch_inact` settings in 16-lane and 8-lane modes. This distinguishes an inactive source from an inactive destination. Mixed row and bank masks, together with the 32-lane runs, show which enables are ignored and which boundary moves.

// File: rtl/lane_share_unit.sv
module lane_share_unit #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*DW-1:0]   src_data,
  input  logic [LANES*DW-1:0]   old_data,
  input  logic [LANES-1:0]      exec_mask,
  input  logic [3:0]            op,
  input  logic [7:0]            arg,
  input  logic [23:0]           sel8,
  input  logic                  mode8,
  input  logic                  wave32,
  input  logic [LANES/16-1:0]   row_en,
  input  logic [3:0]            bank_en,
  input  logic                  bound_zero,
  input  logic                  fetch_inact,
  output logic                  out_valid,
  output logic [LANES*DW-1:0]   result
);
  localparam int LIW  = $clog2(LANES);
  localparam int HALF = LANES / 2;

  logic [LANES*DW-1:0] nxt_all;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int  R  = i / 16;
    localparam int  L  = i % 16;
    localparam int  B  = L / 4;
    localparam bit  UP = (i >= HALF);
    logic [LIW-1:0] s;
    logic           ok;
    logic [4:0]     sum, dif;
    logic [LIW-1:0] wend;
    logic [DW-1:0]  sv, nxt;
    logic           act;

    assign sum  = 5'(L) + {1'b0, arg[3:0]};
    assign dif  = 5'(L) - {1'b0, arg[3:0]};
    assign wend = wave32 ? LIW'(HALF - 1) : LIW'(LANES - 1);

    always_comb begin
      s  = LIW'(i);
      ok = 1'b1;
      if (mode8) begin
        s = LIW'(i - i % 8) + LIW'(sel8[3*(i%8) +: 3]);
      end else begin
        case (op)
          4'd0: s = LIW'(i - i % 4) + LIW'(arg[2*(i%4) +: 2]);
          4'd1: s = LIW'(R*16 + 15 - L);
          4'd2: s = LIW'(i - i % 8 + 7 - i % 8);
          4'd3: begin s = LIW'(R*16) + LIW'(sum[3:0]); ok = !sum[4]; end
          4'd4: begin s = LIW'(R*16) + LIW'(dif[3:0]); ok = !dif[4]; end
          4'd5: s = LIW'(R*16) + LIW'(dif[3:0]);
          4'd6: begin s = LIW'(i) + 1'b1; ok = (LIW'(i) != wend); end
          4'd7: s = (LIW'(i) == wend) ? '0 : LIW'(i) + 1'b1;
          4'd8: begin s = LIW'(i) - 1'b1; ok = (i != 0); end
          4'd9: s = (i == 0) ? wend : LIW'(i) - 1'b1;
          4'd10: begin s = LIW'(R*16 + 15 - 16); ok = (R != 0); end
          4'd11: begin s = LIW'(31); ok = (R >= 2); end
          default: s = LIW'(i);
        endcase
      end
    end

    assign act = exec_mask[s];
    assign sv  = src_data[s*DW +: DW];

    always_comb begin
      if (!exec_mask[i] || (wave32 && UP))        nxt = old_data[i*DW +: DW];
      else if (mode8)                             nxt = (act || fetch_inact) ? sv : '0;
      else if (!(row_en[R] && bank_en[B]))        nxt = old_data[i*DW +: DW];
      else if (ok && (act || fetch_inact))        nxt = sv;
      else if (bound_zero)                        nxt = '0;
      else                                        nxt = old_data[i*DW +: DW];
    end

    assign nxt_all[i*DW +: DW] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_all;
    end
  end
endmodule

// File: rtl/lane_share_unit_chk.sv
module lane_share_unit_chk #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*DW-1:0] old_data,
  input logic [LANES-1:0]    exec_mask,
  input logic                mode8,
  input logic                wave32,
  input logic [LANES/16-1:0] row_en,
  input logic [3:0]          bank_en,
  input logic                out_valid,
  input logic [LANES*DW-1:0] result
);
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    localparam int R = i / 16;
    localparam int B = (i % 16) / 4;

    p_dest_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !exec_mask[i] |=> result[i*DW +: DW] == $past(old_data[i*DW +: DW]));

    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !mode8 && !(row_en[R] && bank_en[B])
      |=> result[i*DW +: DW] == $past(old_data[i*DW +: DW]));

    if (i >= LANES / 2) begin : g_up
      p_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && wave32 |=> result[i*DW +: DW] == $past(old_data[i*DW +: DW]));
    end
  end
endmodule

bind lane_share_unit lane_share_unit_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .old_data(old_data),
  .exec_mask(exec_mask), .mode8(mode8), .wave32(wave32), .row_en(row_en),
  .bank_en(bank_en), .out_valid(out_valid), .result(result)
);

// File: tb/lane_share_unit_tb_top.sv
module lane_share_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam int W = N * 32;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] src_data, old_data;
  logic [N-1:0] exec_mask = '1;
  logic [3:0]   op = '0;
  logic [7:0]   arg = '0;
  logic [23:0]  sel8 = '0;
  logic mode8 = 0, wave32 = 0, bound_zero = 0, fetch_inact = 0;
  logic [3:0]   row_en = 4'hF, bank_en = 4'hF;
  logic         out_valid;
  logic [W-1:0] result;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_share_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
    .old_data(old_data), .exec_mask(exec_mask), .op(op), .arg(arg),
    .sel8(sel8), .mode8(mode8), .wave32(wave32), .row_en(row_en),
    .bank_en(bank_en), .bound_zero(bound_zero), .fetch_inact(fetch_inact),
    .out_valid(out_valid), .result(result));

  function automatic logic [W-1:0] model();
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin
      int row = i / 16, li = i % 16, bk = li / 4, n = arg[3:0], src = i;
      int wend = wave32 ? 31 : 63;
      bit geo = 1;
      logic [31:0] v;
      if (mode8) src = (i / 8) * 8 + sel8[3*(i%8) +: 3];
      else case (op)
        0: src = (i / 4) * 4 + arg[2*(i%4) +: 2];
        1: src = row * 16 + (15 - li);
        2: src = (i / 8) * 8 + (7 - i % 8);
        3: begin src = row * 16 + li + n; geo = (li + n <= 15); end
        4: begin src = row * 16 + li - n; geo = (li >= n); end
        5: src = row * 16 + (li - n + 16) % 16;
        6: begin src = i + 1; geo = (i != wend); end
        7: src = (i == wend) ? 0 : i + 1;
        8: begin src = i - 1; geo = (i != 0); end
        9: src = (i == 0) ? wend : i - 1;
        10: begin src = row * 16 - 1; geo = (row >= 1); end
        11: begin src = 31; geo = (row >= 2); end
        default: src = i;
      endcase
      if (src < 0 || src >= N) begin src = 0; geo = 0; end
      if (!exec_mask[i] || (wave32 && i >= 32)) v = old_data[i*32 +: 32];
      else if (mode8) v = (exec_mask[src] || fetch_inact) ? src_data[src*32 +: 32] : 32'd0;
      else if (!row_en[row] || !bank_en[bk]) v = old_data[i*32 +: 32];
      else if (geo && (exec_mask[src] || fetch_inact)) v = src_data[src*32 +: 32];
      else if (bound_zero) v = 32'd0;
      else v = old_data[i*32 +: 32];
      r[i*32 +: 32] = v;
    end
    return r;
  endfunction

  task automatic check_vec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      for (int i = 0; i < N; i++)
        if (act[i*32 +: 32] !== exp[i*32 +: 32]) begin
          $display("FAIL %s lane %0d: actual %h expected %h", tag, i,
                   act[i*32 +: 32], exp[i*32 +: 32]);
          break;
        end
    end
  endtask

  task automatic send(string tag);
    last_exp = model();
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic defaults();
    exec_mask = '1; op = 0; arg = 0; sel8 = 0; mode8 = 0; wave32 = 0;
    bound_zero = 0; fetch_inact = 0; row_en = 4'hF; bank_en = 4'hF;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12 unexpected out_valid: actual 1 expected 0");
      end else begin
        string t = tag_q.pop_front();
        check_vec(t, result, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      src_data[i*32 +: 32] = 32'hA000_0001 + i * 32'h0001_0101;
      old_data[i*32 +: 32] = 32'h5E00_0000 + i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R12 reset state: actual valid=%b expected valid=0 and zero result", out_valid);
    end

    op = 0; arg = 8'h1B; send("R1 quad reverse");
    arg = 8'h00; send("R1 quad lane0");
    arg = 8'hE4; send("R1 quad identity");
    op = 1; send("R2 row mirror");
    op = 2; send("R2 half mirror");
    op = 3; arg = 3; bound_zero = 1; send("R3 R7 row shl 3 zero");
    op = 4; arg = 5; bound_zero = 0; send("R3 R7 row shr 5 keep");
    op = 5; arg = 15; send("R3 row ror 15");
    op = 3; arg = 15; bound_zero = 0; send("R3 R7 row shl 15 keep");
    op = 6; bound_zero = 1; send("R4 wave shl");
    op = 7; send("R4 wave rol");
    op = 8; bound_zero = 0; send("R4 wave shr");
    op = 9; send("R4 wave ror");
    op = 10; bound_zero = 0; send("R5 bcast15 keep");
    op = 11; bound_zero = 1; send("R5 bcast31 zero");
    op = 12; send("R5 unused op copy");
    op = 1; row_en = 4'b0101; bank_en = 4'b0011; send("R6 row bank masks");
    defaults();
    op = 3; arg = 1; bound_zero = 1; exec_mask = 64'h0F0F_33CC_A5A5_FFFE;
    send("R8 R10 inactive source zero");
    fetch_inact = 1; send("R8 inactive source fetch");
    bound_zero = 0; fetch_inact = 0; op = 8; send("R8 R10 inactive keep");
    defaults();
    mode8 = 1; sel8 = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    send("R9 sel8 reverse");
    sel8 = {3'd5, 3'd5, 3'd2, 3'd0, 3'd7, 3'd1, 3'd1, 3'd3};
    exec_mask = 64'hF0F0_5A5A_C3C3_FFFF; row_en = 4'b0000; bank_en = 4'b0110;
    send("R9 sel8 inactive zero masks ignored");
    fetch_inact = 1; send("R9 sel8 inactive fetch");
    defaults();
    wave32 = 1; op = 7; send("R11 wave32 rol");
    op = 6; bound_zero = 1; send("R11 wave32 shl");
    op = 9; send("R11 wave32 ror");

    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== last_exp) begin
      n_fail++;
      $display("FAIL R12 hold: actual valid=%b result changed, expected valid=0 held", out_valid);
    end
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R12 missing results: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule